// File: doc/BRIEF.md
# Indexed Bitmap Line Renderer

This block draws one horizontal line of a 240x160 bitmap picture. Each stored pixel is one byte, and that byte is an index into a table of 15-bit colours. A timing generator outside the block supplies the line number and a one-cycle start pulse. The block then walks across the 240 columns of that line. For each column it reads the pixel byte from video memory, looks the byte up in colour RAM, and streams the colour out at one pixel per clock. Each beat carries both the 15-bit colour and its 24-bit expansion.

Video memory holds two complete frame pages. A control bit picks the page that a line is drawn from, so software can draw into one page while the other is on screen. The renderer only acts when the control word selects bitmap mode 4. If blanking is forced, or if the bitmap layer is switched off, it sends a line of constant colour and reads no memory. Both memories are read through plain request ports with one cycle of read latency.

Top module: `bmp_line_render`

## Requirements
- R1: After reset no pixel beat is valid, `busy_o` is low and no memory read is requested.
- R2: With control bits [2:0] = 4, bit 7 = 0 and bit 10 = 1, a start pulse yields exactly 240 valid beats. Beat x (0..239) carries the colour-RAM entry selected by the video byte at page + x + 240*line.
- R3: Control bit 4 selects the frame page: 0 uses byte offset 0x0000, 1 uses byte offset 0xA000.
- R4: Colour RAM is read at byte address 2*index, which is the first bank of entries. The returned 16-bit word supplies the pixel colour through its bits [14:0].
- R5: `pix_rgb24_o` is 0x00RRGGBB. The five-bit channels come from RGB15 bits [4:0] (red), [9:5] (green) and [14:10] (blue), and each channel c widens to {c, c[4:2]}.
- R6: `pix_last_o` is high on the beat of column 239 and on no other beat.
- R7: With control bit 7 (forced blank) set in mode 4, the line is 240 beats of 0x7FFF, and no video or colour read is made.
- R8: With bit 7 clear and bit 10 clear in mode 4, the line is 240 beats of the `BACKDROP` colour (default 0x0000), and no memory read is made.
- R9: A start pulse while control bits [2:0] are not 4 is ignored: no beat, no read, and `busy_o` stays low.
- R10: A start pulse while `busy_o` is high is ignored. The line in progress keeps its line number and its page, and still gives exactly 240 beats.
- R11: The first beat is valid on the third rising edge after the edge that accepts the start. The remaining beats follow on consecutive cycles with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to draw a line |
| ctrl_i | input | 16 | Display control word, sampled when a start is accepted |
| line_i | input | 8 | Line number, sampled when a start is accepted |
| vram_rd_o | output | 1 | Video memory read request |
| vram_addr_o | output | 17 | Video memory byte address |
| vram_data_i | input | 8 | Video memory byte, one cycle after the request |
| pal_rd_o | output | 1 | Colour RAM read request |
| pal_addr_o | output | 9 | Colour RAM byte address |
| pal_data_i | input | 16 | Colour RAM word, one cycle after the request |
| busy_o | output | 1 | A line is being fetched or is still in the pipeline |
| pix_valid_o | output | 1 | Pixel beat valid |
| pix_last_o | output | 1 | Beat is column 239 |
| pix_rgb15_o | output | 15 | Pixel colour, 15-bit |
| pix_rgb24_o | output | 32 | Pixel colour, 0x00RRGGBB |

## Verification
The hardest case to reach is a start pulse that arrives in the middle of a line while the pipeline is full. It must change neither the latched line number nor the address stream. The stimulus raises the pulse together with a different line number at column 100 of a running line. It then checks every remaining beat against values computed from the original line, and checks that exactly 240 beats come out. A second hard case is the blank-line paths, which must make no reads at all. The bench counts read requests at the memory ports for each line and compares them with the number expected for that line.

// File: rtl/lcd_bmp_pkg.sv
package lcd_bmp_pkg;

  typedef enum logic [1:0] {
    FILL_MEM      = 2'd0,
    FILL_WHITE    = 2'd1,
    FILL_BACKDROP = 2'd2
  } fill_e;

  typedef struct packed {
    logic [2:0] mode;
    logic       page;
    logic       blank;
    logic       bg2_on;
  } ctrl_t;

  localparam logic [14:0] WHITE15 = 15'h7fff;

  function automatic ctrl_t decode_ctrl(input logic [15:0] w);
    ctrl_t c;
    c.mode   = w[2:0];
    c.page   = w[4];
    c.blank  = w[7];
    c.bg2_on = w[10];
    return c;
  endfunction

  function automatic fill_e pick_fill(input ctrl_t c);
    if (c.blank)        return FILL_WHITE;
    else if (!c.bg2_on) return FILL_BACKDROP;
    else                return FILL_MEM;
  endfunction

  function automatic logic [31:0] line_base(input logic page, input logic [7:0] line,
                                            input int unsigned line_w,
                                            input int unsigned page1_ofs);
    logic [31:0] ofs;
    ofs = page ? page1_ofs : 32'd0;
    return ofs + line_w * {24'd0, line};
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [31:0] rgb15_to_24(input logic [14:0] c);
    return {8'h00, widen5(c[4:0]), widen5(c[9:5]), widen5(c[14:10])};
  endfunction

endpackage

// File: rtl/bmp_fetch_ctrl.sv
module bmp_fetch_ctrl
  import lcd_bmp_pkg::*;
#(
  parameter int unsigned LINE_W      = 240,
  parameter int unsigned PAGE1_OFS   = 32'h0000_a000,
  parameter int unsigned VADDR_W     = 17,
  parameter int unsigned BITMAP_MODE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [15:0]        ctrl_i,
  input  logic [7:0]         line_i,
  input  logic               pipe_busy_i,
  output logic               vram_rd_o,
  output logic [VADDR_W-1:0] vram_addr_o,
  output logic               s0_valid_o,
  output logic               s0_last_o,
  output fill_e              s0_fill_o,
  output logic               busy_o
);

  localparam int unsigned XW = $clog2(LINE_W);
  localparam logic [XW-1:0] X_LAST = XW'(LINE_W - 1);

  ctrl_t              cin;
  logic               active_q;
  logic [XW-1:0]      x_q;
  logic [VADDR_W-1:0] base_q;
  fill_e              fill_q;
  logic               line_begin;
  logic               line_done;

  assign cin        = decode_ctrl(ctrl_i);
  assign busy_o     = active_q | pipe_busy_i;
  assign line_begin = start_i && !busy_o && (cin.mode == 3'(BITMAP_MODE));
  assign line_done  = active_q && (x_q == X_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      x_q      <= '0;
      base_q   <= '0;
      fill_q   <= FILL_MEM;
    end else if (line_begin) begin
      active_q <= 1'b1;
      x_q      <= '0;
      base_q   <= VADDR_W'(line_base(cin.page, line_i, LINE_W, PAGE1_OFS));
      fill_q   <= pick_fill(cin);
    end else if (active_q) begin
      x_q <= x_q + 1'b1;
      if (line_done) active_q <= 1'b0;
    end
  end

  assign vram_addr_o = base_q + VADDR_W'(x_q);
  assign vram_rd_o   = active_q && (fill_q == FILL_MEM);
  assign s0_valid_o  = active_q;
  assign s0_last_o   = line_done;
  assign s0_fill_o   = fill_q;

  // R9
  ignore_other_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (ctrl_i[2:0] != 3'(BITMAP_MODE))) |=> !active_q);

  // R10
  hold_base_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !line_done) |=> $stable(base_q) && (x_q == $past(x_q) + 1'b1));

endmodule

// File: rtl/bmp_pal_stage.sv
module bmp_pal_stage
  import lcd_bmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s0_valid_i,
  input  logic        s0_last_i,
  input  fill_e       s0_fill_i,
  input  logic        vram_rd_i,
  input  logic [7:0]  vram_data_i,
  output logic        pal_rd_o,
  output logic [8:0]  pal_addr_o,
  output logic        s2_valid_o,
  output logic        s2_last_o,
  output fill_e       s2_fill_o,
  output logic        pipe_busy_o
);

  logic  s1_valid_q, s1_last_q;
  fill_e s1_fill_q;
  logic  s2_valid_q, s2_last_q;
  fill_e s2_fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_last_q  <= 1'b0;
      s1_fill_q  <= FILL_MEM;
      s2_valid_q <= 1'b0;
      s2_last_q  <= 1'b0;
      s2_fill_q  <= FILL_MEM;
    end else begin
      s1_valid_q <= s0_valid_i;
      s1_last_q  <= s0_last_i;
      s1_fill_q  <= s0_fill_i;
      s2_valid_q <= s1_valid_q;
      s2_last_q  <= s1_last_q;
      s2_fill_q  <= s1_fill_q;
    end
  end

  assign pal_addr_o  = {vram_data_i, 1'b0};
  assign pal_rd_o    = s1_valid_q && (s1_fill_q == FILL_MEM);
  assign s2_valid_o  = s2_valid_q;
  assign s2_last_o   = s2_last_q;
  assign s2_fill_o   = s2_fill_q;
  assign pipe_busy_o = s1_valid_q | s2_valid_q;

  // R2
  pal_follows_vram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_rd_o |-> $past(vram_rd_i));

endmodule

// File: rtl/bmp_colour_out.sv
module bmp_colour_out
  import lcd_bmp_pkg::*;
#(
  parameter logic [14:0] BACKDROP = 15'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s2_valid_i,
  input  logic        s2_last_i,
  input  fill_e       s2_fill_i,
  input  logic [15:0] pal_data_i,
  output logic        pix_valid_o,
  output logic        pix_last_o,
  output logic [14:0] pix_rgb15_o,
  output logic [31:0] pix_rgb24_o
);

  logic [14:0] colour;

  always_comb begin
    unique case (s2_fill_i)
      FILL_WHITE:    colour = WHITE15;
      FILL_BACKDROP: colour = BACKDROP;
      default:       colour = pal_data_i[14:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid_o <= 1'b0;
      pix_last_o  <= 1'b0;
      pix_rgb15_o <= '0;
      pix_rgb24_o <= '0;
    end else begin
      pix_valid_o <= s2_valid_i;
      pix_last_o  <= s2_valid_i && s2_last_i;
      if (s2_valid_i) begin
        pix_rgb15_o <= colour;
        pix_rgb24_o <= rgb15_to_24(colour);
      end
    end
  end

  // R6
  last_inside_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_last_o |-> pix_valid_o);

  // R7
  blank_gives_white_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid_i && s2_fill_i == FILL_WHITE) |=> (pix_rgb15_o == 15'h7fff));

endmodule

// File: rtl/bmp_line_render.sv
module bmp_line_render
  import lcd_bmp_pkg::*;
#(
  parameter int unsigned LINE_W      = 240,
  parameter int unsigned PAGE1_OFS   = 32'h0000_a000,
  parameter int unsigned VADDR_W     = 17,
  parameter int unsigned BITMAP_MODE = 4,
  parameter logic [14:0] BACKDROP    = 15'h0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [15:0]        ctrl_i,
  input  logic [7:0]         line_i,
  output logic               vram_rd_o,
  output logic [VADDR_W-1:0] vram_addr_o,
  input  logic [7:0]         vram_data_i,
  output logic               pal_rd_o,
  output logic [8:0]         pal_addr_o,
  input  logic [15:0]        pal_data_i,
  output logic               busy_o,
  output logic               pix_valid_o,
  output logic               pix_last_o,
  output logic [14:0]        pix_rgb15_o,
  output logic [31:0]        pix_rgb24_o
);

  logic  s0_valid, s0_last, s2_valid, s2_last, pipe_busy;
  fill_e s0_fill, s2_fill;

  bmp_fetch_ctrl #(
    .LINE_W(LINE_W), .PAGE1_OFS(PAGE1_OFS),
    .VADDR_W(VADDR_W), .BITMAP_MODE(BITMAP_MODE)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
    .line_i(line_i), .pipe_busy_i(pipe_busy | pix_valid_o),
    .vram_rd_o(vram_rd_o), .vram_addr_o(vram_addr_o),
    .s0_valid_o(s0_valid), .s0_last_o(s0_last), .s0_fill_o(s0_fill),
    .busy_o(busy_o)
  );

  bmp_pal_stage u_pal (
    .clk(clk), .rst_n(rst_n),
    .s0_valid_i(s0_valid), .s0_last_i(s0_last), .s0_fill_i(s0_fill),
    .vram_rd_i(vram_rd_o), .vram_data_i(vram_data_i),
    .pal_rd_o(pal_rd_o), .pal_addr_o(pal_addr_o),
    .s2_valid_o(s2_valid), .s2_last_o(s2_last), .s2_fill_o(s2_fill),
    .pipe_busy_o(pipe_busy)
  );

  bmp_colour_out #(.BACKDROP(BACKDROP)) u_out (
    .clk(clk), .rst_n(rst_n),
    .s2_valid_i(s2_valid), .s2_last_i(s2_last), .s2_fill_i(s2_fill),
    .pal_data_i(pal_data_i),
    .pix_valid_o(pix_valid_o), .pix_last_o(pix_last_o),
    .pix_rgb15_o(pix_rgb15_o), .pix_rgb24_o(pix_rgb24_o)
  );

  // R11
  beats_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && !pix_last_o) |=> pix_valid_o);

  // R1
  idle_no_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!vram_rd_o && !pal_rd_o && !pix_valid_o));

endmodule

// File: tb/sim_bmp_line_render.sv
module sim_bmp_line_render;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] ctrl_i = 16'h0;
  logic [7:0]  line_i = 8'h0;
  logic        vram_rd_o, pal_rd_o, busy_o, pix_valid_o, pix_last_o;
  logic [16:0] vram_addr_o;
  logic [8:0]  pal_addr_o;
  logic [7:0]  vram_data_i = 8'h0;
  logic [15:0] pal_data_i = 16'h0;
  logic [14:0] pix_rgb15_o;
  logic [31:0] pix_rgb24_o;

  int vectors = 0;
  int fails = 0;
  int vreads = 0;
  int preads = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bmp_line_render u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i), .line_i(line_i),
    .vram_rd_o(vram_rd_o), .vram_addr_o(vram_addr_o), .vram_data_i(vram_data_i),
    .pal_rd_o(pal_rd_o), .pal_addr_o(pal_addr_o), .pal_data_i(pal_data_i),
    .busy_o(busy_o), .pix_valid_o(pix_valid_o), .pix_last_o(pix_last_o),
    .pix_rgb15_o(pix_rgb15_o), .pix_rgb24_o(pix_rgb24_o)
  );

  function automatic logic [7:0] vmem(input int unsigned a);
    return 8'((a * 37) + (a >> 8) + 5);
  endfunction

  function automatic logic [15:0] pmem(input int unsigned byte_addr);
    int unsigned idx;
    idx = byte_addr / 2;
    return 16'(((idx * 263) + 16'h1234) | 32'h8000);
  endfunction

  function automatic logic [31:0] expand(input logic [14:0] c);
    int unsigned r, g, b;
    r = c & 31; g = (c >> 5) & 31; b = (c >> 10) & 31;
    r = (r << 3) | (r >> 2); g = (g << 3) | (g >> 2); b = (b << 3) | (b >> 2);
    return (r << 16) | (g << 8) | b;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (vram_rd_o) begin
      vram_data_i <= vmem(int'(vram_addr_o));
      vreads <= vreads + 1;
    end
    if (pal_rd_o) begin
      pal_data_i <= pmem(int'(pal_addr_o));
      preads <= preads + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // kind: 0 memory line, 1 white, 2 backdrop, 3 no line expected
  task automatic run_line(input logic [15:0] ctrl, input logic [7:0] line, input int kind,
                          input int glitch_at, input string req);
    int unsigned page;
    logic [14:0] e15;
    @(negedge clk);
    vreads = 0; preads = 0;
    ctrl_i = ctrl; line_i = line; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (kind == 3) begin
      for (int i = 0; i < 245; i++) begin
        check(!pix_valid_o && !busy_o, "R9", "idle beat/busy", {30'd0, busy_o, pix_valid_o}, 0);
        @(negedge clk);
      end
      check(vreads == 0 && preads == 0, "R9", "reads", vreads + preads, 0);
      return;
    end
    check(!pix_valid_o, "R11", "early beat 1", pix_valid_o, 0);
    @(negedge clk);
    check(!pix_valid_o, "R11", "early beat 2", pix_valid_o, 0);
    @(negedge clk);
    check(!pix_valid_o, "R11", "early beat 3", pix_valid_o, 0);
    page = ctrl[4] ? 32'ha000 : 0;
    for (int x = 0; x < 240; x++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (kind == 0) e15 = pmem(2 * vmem(page + x + 240 * line))[14:0];
      else if (kind == 1) e15 = 15'h7fff;
      else e15 = 15'h0000;
      check(pix_valid_o, "R11", "beat missing", pix_valid_o, 1);
      check(pix_rgb15_o == e15, req, $sformatf("rgb15 x=%0d", x), pix_rgb15_o, e15);
      check(pix_rgb24_o == expand(e15), "R5", $sformatf("rgb24 x=%0d", x), pix_rgb24_o, expand(e15));
      check(pix_last_o == (x == 239), "R6", $sformatf("last x=%0d", x), pix_last_o, x == 239);
      if (x == glitch_at) begin
        start_i = 1'b1;
        line_i = line + 8'd3;
        ctrl_i = ctrl ^ 16'h0010;
      end
    end
    @(negedge clk);
    check(!pix_valid_o, "R10", "extra beat", pix_valid_o, 0);
    line_i = line; ctrl_i = ctrl;
    if (kind == 0) begin
      check(vreads == 240, "R2", "video reads", vreads, 240);
      check(preads == 240, "R4", "colour reads", preads, 240);
    end else begin
      check(vreads == 0 && preads == 0, kind == 1 ? "R7" : "R8", "reads", vreads + preads, 0);
    end
    @(negedge clk);
    check(!busy_o, "R10", "busy after line", busy_o, 0);
  endtask

  task automatic t_reset;
    check(!pix_valid_o && !busy_o && !vram_rd_o && !pal_rd_o, "R1", "reset state",
          {28'd0, pal_rd_o, vram_rd_o, busy_o, pix_valid_o}, 0);
  endtask

  task automatic t_page0;      run_line(16'h0404, 8'd0, 0, -1, "R2"); endtask
  task automatic t_page1;      run_line(16'h0414, 8'd159, 0, -1, "R3"); endtask
  task automatic t_restart;    run_line(16'h0404, 8'd77, 0, 100, "R10"); endtask
  task automatic t_blank;      run_line(16'h0484, 8'd20, 1, -1, "R7"); endtask
  task automatic t_bg_off;     run_line(16'h0014, 8'd40, 2, -1, "R8"); endtask
  task automatic t_other_mode; run_line(16'h0403, 8'd9, 3, -1, "R9"); endtask
  task automatic t_palette;    run_line(16'h0c14, 8'd5, 0, -1, "R4"); endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page0();
    t_page1();
    t_restart();
    t_blank();
    t_bg_off();
    t_other_mode();
    t_palette();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule